// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This unit collects the three interrupt causes of a serial port (receive FIFO reached its trigger level, receive line idle while data waits, transmit FIFO drained to its trigger level) into a raw status register. A software-written mask selects which causes may interrupt. The masked status and a single combined interrupt line are driven from registers. Software acknowledges a cause by writing a one to its bit in the clear port.

The FIFOs and the serial engine sit outside this unit. It only sees the two fill counts, a one-cycle strobe for each received character, and a one-cycle tick for each bit period. Both level events respond to a crossing of the threshold, not to the level being held. A transmit cause is therefore only raised when the transmit fill falls through its threshold. Unmasking it while the FIFO already sits below the threshold raises nothing, so software has to prime the first transfer itself.

Status bit positions are fixed: bit 0 is receive level, bit 1 is receive timeout, bit 2 is transmit level.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the raw status, mask, masked status and interrupt line are all zero.
- R2: A cycle with `mask_wr_en` high loads `mask_wr_data` into the mask. The new value is visible on `mask_q` after that clock edge.
- R3: `masked_status` equals `raw_status` AND `mask_q`, and `irq` is the OR of the `masked_status` bits. All of them update at the same clock edge as the register that changed.
- R4: A cycle with `clr_wr_en` high clears every raw status bit whose `clr_wr_data` bit is one. Bits written with zero are left unchanged.
- R5: When a set event and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R6: Raw bit 0 is set in the cycle where `rx_fill` first becomes greater than or equal to the receive threshold. It is not set again while the fill stays at or above the threshold. The threshold is DEPTH times 1/8, 2/8, 4/8, 6/8 or 7/8 for `rx_lvl_sel` codes 0, 1, 2, 3 and 4. Codes 5 to 7 act as code 4.
- R7: Raw bit 2 is set in the cycle where `tx_fill` first becomes less than or equal to the transmit threshold, after having been above it. `tx_lvl_sel` uses the same code table as R6. Unmasking bit 2 while the fill stays at or below the threshold raises no interrupt.
- R8: Raw bit 1 is set on the TIMEOUT_BITS-th `bit_tick` counted while `rx_fill` is nonzero and no `rx_char_strobe` occurs. A strobe, or an empty FIFO, restarts the count.
- R9: Raw bit 1 clears whenever `rx_fill` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_fill | input | FILL_W | Receive FIFO fill count |
| tx_fill | input | FILL_W | Transmit FIFO fill count |
| rx_char_strobe | input | 1 | One-cycle pulse per received character |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| rx_lvl_sel | input | 3 | Receive trigger level code |
| tx_lvl_sel | input | 3 | Transmit trigger level code |
| mask_wr_en | input | 1 | Mask write enable |
| mask_wr_data | input | 3 | New mask value |
| clr_wr_en | input | 1 | Clear write enable |
| clr_wr_data | input | 3 | Write-one-to-clear bits |
| raw_status | output | 3 | Raw cause bits |
| mask_q | output | 3 | Current mask |
| masked_status | output | 3 | Raw status AND mask |
| irq | output | 1 | Combined interrupt line |

## Verification
The receive fill is stepped to just below and then exactly onto the threshold for several level codes, including an out-of-range code. This separates a greater-or-equal compare from a strict compare, and confirms the clamping of codes 5 to 7. Fill values are then held after a clear, which tells a crossing detector apart from a level detector. The transmit path gets the same treatment, plus a late mask enable to prove its edge behaviour.

Idle periods of exactly one tick short of the limit and exactly at the limit pin down the timeout count, and a character strobe in mid-count shows that the count restarts. Simultaneous set and clear, and partial mask changes with several causes pending, separate the set-over-clear priority and the AND/OR output logic.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned SRC_RXLVL = 0;
  localparam int unsigned SRC_RXTMO = 1;
  localparam int unsigned SRC_TXLVL = 2;

  // Threshold in eighths of the FIFO depth for a level code.
  function automatic logic [31:0] lvl_eighths(input logic [2:0] sel);
    case (sel)
      3'd0:    lvl_eighths = 32'd1;
      3'd1:    lvl_eighths = 32'd2;
      3'd2:    lvl_eighths = 32'd4;
      3'd3:    lvl_eighths = 32'd6;
      default: lvl_eighths = 32'd7;
    endcase
  endfunction
endpackage

// File: rtl/irq_level_edge.sv
module irq_level_edge #(
  parameter int DEPTH  = 16,
  parameter int FILL_W = 5,
  parameter bit RISING = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FILL_W-1:0] fill,
  input  logic [2:0]        sel,
  output logic              crossed
);
  import uart_irq_pkg::*;

  localparam logic [31:0] DEPTH_U = 32'(DEPTH);

  logic [31:0]       thr_wide;
  logic [FILL_W-1:0] thr;
  logic              cond;
  logic              cond_q;

  assign thr_wide = (DEPTH_U * lvl_eighths(sel)) >> 3;
  assign thr      = thr_wide[FILL_W-1:0];

  generate
    if (RISING) begin : g_rise
      assign cond = (fill >= thr);
    end else begin : g_fall
      assign cond = (fill <= thr);
    end
  endgenerate

  // The falling variant resets as "already below", so an empty FIFO
  // at start-up produces no event.
  always_ff @(posedge clk) begin
    if (rst) cond_q <= ~RISING;
    else     cond_q <= cond;
  end

  assign crossed = cond & ~cond_q;
endmodule

// File: rtl/irq_rx_timeout.sv
module irq_rx_timeout #(
  parameter int FILL_W       = 5,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FILL_W-1:0] fill,
  input  logic              char_strobe,
  input  logic              bit_tick,
  output logic              fire,
  output logic              empty
);
  localparam int CNT_W = $clog2(TIMEOUT_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TIMEOUT_BITS);

  logic [CNT_W-1:0] cnt;

  assign empty = (fill == '0);
  assign fire  = bit_tick && !char_strobe && !empty && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || char_strobe || empty) cnt <= '0;
    else if (bit_tick && cnt != FULL) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] auto_clr,
  input  logic         clr_wr_en,
  input  logic [N-1:0] clr_wr_data,
  input  logic         mask_wr_en,
  input  logic [N-1:0] mask_wr_data,
  output logic [N-1:0] raw_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] masked_q,
  output logic         irq_q
);
  logic [N-1:0] raw_d;
  logic [N-1:0] mask_d;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_comb begin
        if (set_vec[i])                                raw_d[i] = 1'b1;
        else if ((clr_wr_en && clr_wr_data[i]) || auto_clr[i]) raw_d[i] = 1'b0;
        else                                           raw_d[i] = raw_q[i];
      end
    end
  endgenerate

  assign mask_d = mask_wr_en ? mask_wr_data : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= '0;
      mask_q   <= '0;
      masked_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      raw_q    <= raw_d;
      mask_q   <= mask_d;
      masked_q <= raw_d & mask_d;
      irq_q    <= |(raw_d & mask_d);
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int DEPTH        = 16,
  parameter int TIMEOUT_BITS = 32,
  parameter int FILL_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] tx_fill,
  input  logic              rx_char_strobe,
  input  logic              bit_tick,
  input  logic [2:0]        rx_lvl_sel,
  input  logic [2:0]        tx_lvl_sel,
  input  logic              mask_wr_en,
  input  logic [2:0]        mask_wr_data,
  input  logic              clr_wr_en,
  input  logic [2:0]        clr_wr_data,
  output logic [2:0]        raw_status,
  output logic [2:0]        mask_q,
  output logic [2:0]        masked_status,
  output logic              irq
);
  import uart_irq_pkg::*;

  logic rx_cross, tx_cross, tmo_fire, rx_empty;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] auto_clr;

  irq_level_edge #(.DEPTH(DEPTH), .FILL_W(FILL_W), .RISING(1'b1)) u_rx_lvl (
    .clk(clk), .rst(rst), .fill(rx_fill), .sel(rx_lvl_sel), .crossed(rx_cross));

  irq_level_edge #(.DEPTH(DEPTH), .FILL_W(FILL_W), .RISING(1'b0)) u_tx_lvl (
    .clk(clk), .rst(rst), .fill(tx_fill), .sel(tx_lvl_sel), .crossed(tx_cross));

  irq_rx_timeout #(.FILL_W(FILL_W), .TIMEOUT_BITS(TIMEOUT_BITS)) u_tmo (
    .clk(clk), .rst(rst), .fill(rx_fill), .char_strobe(rx_char_strobe),
    .bit_tick(bit_tick), .fire(tmo_fire), .empty(rx_empty));

  always_comb begin
    set_vec             = '0;
    set_vec[SRC_RXLVL]  = rx_cross;
    set_vec[SRC_RXTMO]  = tmo_fire;
    set_vec[SRC_TXLVL]  = tx_cross;
    auto_clr            = '0;
    auto_clr[SRC_RXTMO] = rx_empty;
  end

  irq_status_bank #(.N(NUM_SRC)) u_bank (
    .clk(clk), .rst(rst), .set_vec(set_vec), .auto_clr(auto_clr),
    .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .raw_q(raw_status), .mask_q(mask_q), .masked_q(masked_status), .irq_q(irq));
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int FILL_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [FILL_W-1:0] rx_fill,
  input logic [2:0]        set_vec,
  input logic              mask_wr_en,
  input logic [2:0]        mask_wr_data,
  input logic              clr_wr_en,
  input logic [2:0]        clr_wr_data,
  input logic [2:0]        raw_status,
  input logic [2:0]        mask_q,
  input logic [2:0]        masked_status,
  input logic              irq
);
  // R2
  p_mask_load_r2: assert property (@(posedge clk) disable iff (rst)
    mask_wr_en |=> (mask_q == $past(mask_wr_data)));
  // R3
  p_masked_and_r3: assert property (@(posedge clk) disable iff (rst)
    masked_status == (raw_status & mask_q));
  p_irq_or_r3: assert property (@(posedge clk) disable iff (rst)
    irq == (|masked_status));
  // R4
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clr_wr_en |=> ((raw_status & $past(clr_wr_data) & ~$past(set_vec)) == 3'b000));
  // R5
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (set_vec != 3'b000) |=> ((raw_status & $past(set_vec)) == $past(set_vec)));
  // R9
  p_tmo_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_fill == '0) |=> !raw_status[1]);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.FILL_W(FILL_W)) u_chk (
  .clk(clk), .rst(rst), .rx_fill(rx_fill), .set_vec(set_vec),
  .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
  .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
  .raw_status(raw_status), .mask_q(mask_q),
  .masked_status(masked_status), .irq(irq));

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int DEPTH = 16;
  localparam int TMO   = 32;
  localparam int FW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [FW-1:0] rx_fill = '0, tx_fill = '0;
  logic rx_char_strobe = 1'b0, bit_tick = 1'b0;
  logic [2:0] rx_lvl_sel = 3'd0, tx_lvl_sel = 3'd0;
  logic mask_wr_en = 1'b0, clr_wr_en = 1'b0;
  logic [2:0] mask_wr_data = '0, clr_wr_data = '0;
  logic [2:0] raw_status, mask_q, masked_status;
  logic irq;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  uart_irq_ctrl #(.DEPTH(DEPTH), .TIMEOUT_BITS(TMO)) i_uart_irq_ctrl (
    .clk(clk), .rst(rst), .rx_fill(rx_fill), .tx_fill(tx_fill),
    .rx_char_strobe(rx_char_strobe), .bit_tick(bit_tick),
    .rx_lvl_sel(rx_lvl_sel), .tx_lvl_sel(tx_lvl_sel),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
    .raw_status(raw_status), .mask_q(mask_q),
    .masked_status(masked_status), .irq(irq));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_mask(input logic [2:0] m);
    mask_wr_en = 1'b1; mask_wr_data = m; tick();
    mask_wr_en = 1'b0;
  endtask

  task automatic write_clr(input logic [2:0] c);
    clr_wr_en = 1'b1; clr_wr_data = c; tick();
    clr_wr_en = 1'b0; clr_wr_data = '0;
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; tick();
      bit_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 raw", {5'd0, raw_status}, 8'h0);
    chk("R1 mask", {5'd0, mask_q}, 8'h0);
    chk("R1 irq", {7'd0, irq}, 8'h0);
  endtask

  task automatic t_rx_level();
    rx_fill = 1; tick();
    chk("R6 below thr", {5'd0, raw_status}, 8'h0);
    rx_fill = 2; tick();
    chk("R6 at thr", {5'd0, raw_status}, 8'h1);
    chk("R3 masked off", {7'd0, irq}, 8'h0);
    write_mask(3'b001);
    chk("R2 mask load", {5'd0, mask_q}, 8'h1);
    chk("R3 irq on unmask", {7'd0, irq}, 8'h1);
    write_clr(3'b001);
    chk("R4 clear", {5'd0, raw_status}, 8'h0);
    chk("R3 irq after clear", {7'd0, irq}, 8'h0);
    tick();
    chk("R6 no reset while held", {5'd0, raw_status}, 8'h0);
    rx_fill = 0; tick();
    rx_lvl_sel = 3'd2; rx_fill = 7; tick();
    chk("R6 code2 below", {5'd0, raw_status}, 8'h0);
    rx_fill = 8; tick();
    chk("R6 code2 at", {5'd0, raw_status}, 8'h1);
    write_clr(3'b001);
    rx_fill = 0; tick();
    rx_lvl_sel = 3'd6; rx_fill = 13; tick();
    chk("R6 code6 below", {5'd0, raw_status}, 8'h0);
    rx_fill = 14; tick();
    chk("R6 code6 clamps to 7/8", {5'd0, raw_status}, 8'h1);
    write_clr(3'b001);
    rx_fill = 0; rx_lvl_sel = 3'd0; tick();
    write_mask(3'b000);
  endtask

  task automatic t_tx_level();
    write_mask(3'b100);
    tx_fill = 10; tick();
    chk("R7 above", {5'd0, raw_status}, 8'h0);
    tx_fill = 2; tick();
    chk("R7 falls through", {5'd0, raw_status}, 8'h4);
    chk("R7 irq", {7'd0, irq}, 8'h1);
    write_clr(3'b100);
    write_mask(3'b000);
    tick();
    write_mask(3'b100);
    chk("R7 late unmask no irq", {7'd0, irq}, 8'h0);
    chk("R7 late unmask raw", {5'd0, raw_status}, 8'h0);
    tx_fill = 3; tick();
    tx_fill = 2; tick();
    chk("R7 second crossing", {5'd0, raw_status}, 8'h4);
    write_clr(3'b100);
    write_mask(3'b000);
  endtask

  task automatic t_timeout();
    write_mask(3'b010);
    rx_fill = 1; tick();
    pulse_ticks(TMO - 1);
    chk("R8 one short", {5'd0, raw_status}, 8'h0);
    pulse_ticks(1);
    chk("R8 at limit", {5'd0, raw_status}, 8'h2);
    chk("R8 irq", {7'd0, irq}, 8'h1);
    rx_fill = 0; tick();
    chk("R9 empty clears", {5'd0, raw_status}, 8'h0);
    rx_fill = 1; tick();
    pulse_ticks(20);
    rx_char_strobe = 1'b1; tick();
    rx_char_strobe = 1'b0;
    pulse_ticks(20);
    chk("R8 strobe restarts", {5'd0, raw_status}, 8'h0);
    pulse_ticks(TMO - 20);
    chk("R8 limit after strobe", {5'd0, raw_status}, 8'h2);
    rx_fill = 0; tick();
    write_mask(3'b000);
  endtask

  task automatic t_set_wins();
    rx_fill = 2; clr_wr_en = 1'b1; clr_wr_data = 3'b001; tick();
    clr_wr_en = 1'b0; clr_wr_data = '0;
    chk("R5 set beats clear", {5'd0, raw_status}, 8'h1);
    write_clr(3'b001);
    rx_fill = 0; tick();
  endtask

  task automatic t_combined();
    write_mask(3'b101);
    tx_fill = 10; tick();
    tx_fill = 2; rx_fill = 2; tick();
    chk("R3 both raw", {5'd0, raw_status}, 8'h5);
    chk("R3 both masked", {5'd0, masked_status}, 8'h5);
    write_mask(3'b100);
    chk("R3 partial mask", {5'd0, masked_status}, 8'h4);
    write_clr(3'b100);
    chk("R4 only written bit", {5'd0, raw_status}, 8'h1);
    chk("R3 irq drops", {7'd0, irq}, 8'h0);
  endtask

  initial begin
    fork
      begin
        tick(); tick();
        rst = 1'b0;
        t_reset();
        t_rx_level();
        t_tx_level();
        t_timeout();
        t_set_wins();
        t_combined();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule